// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block sequences a gated logic domain through power-up and power-down. It runs on the reference oscillator clock and is controlled through one 32-bit control and status word, which is written and read over a plain register port. The block drives two groups of power switches: a small first group that limits inrush current, and the remaining bulk switches. It also drives the domain clock enable and the isolation clamp, and reports a power-good flag.

A request to collapse or restore comes either from a bit in the control word or, in hardware-trigger mode, from an external input. A state machine then steps through the stages. Each stage wait is 2^n reference cycles, with n taken from its own 4-bit field. A software-override mode bypasses the stepping and forces the full-on or full-off output pattern directly. A request change that arrives during a sequence does not interrupt it. It is acted on once the domain reaches a stable on or off state.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset the domain is off: both switch enables, the clock enable and power-good are 0, the clamp is 1, and the control word reads 0x00000001 (collapse requested, all waits 0, both mode bits 0).
- R2: Control word layout: bit 0 collapse request (1 = off), bit 1 hardware-trigger mode, bit 2 software override, bits 15:12 clock-off wait, bits 19:16 first-group wait, bits 23:20 bulk-group wait. Bit 31 reads the power-good flag and ignores writes. All other bits read 0.
- R3: The request is sampled on the clock edge after the control word is written. The first switch group turns on at that edge, and the bulk group turns on 2^F cycles later, where F is bits 19:16.
- R4: Power-good rises and the clamp releases 2^B cycles after the bulk group turns on, where B is bits 23:20. Power-good is never 1 while the clamp is 1.
- R5: The clock enable rises exactly 4 cycles after power-good rises.
- R6: On a collapse request in the on state, power-good and the clock enable fall on the next edge. The clamp rises 2^C cycles later, where C is bits 15:12. Both switch groups turn off one cycle after the clamp rises.
- R7: A request change made during a sequence is held. The running sequence completes, and the domain then goes to the state the latest request asks for.
- R8: In hardware-trigger mode the external collapse input (1 = off) is the request source, with the same stage timing, and writes to bit 0 have no effect.
- R9: In software-override mode the outputs take the full-on pattern (all switches, clock enable, power-good 1, clamp 0) or the full-off pattern one cycle after the request is sampled, with no stage waits.
- R10: At all times the clock enable is 1 only with power-good, the bulk group is on only with the first group, and the clamp is 1 whenever the bulk group is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data with status in bit 31 |
| hw_collapse_req | input | 1 | External collapse request, 1 = off, used in hardware-trigger mode |
| sw_few_en | output | 1 | Enable for the first small group of head switches |
| sw_rest_en | output | 1 | Enable for the remaining head switches |
| iso_clamp | output | 1 | Isolation clamp, 1 = domain outputs clamped |
| clk_en | output | 1 | Domain clock enable |
| pwr_good | output | 1 | Domain fully powered |

## Verification
On every cycle the assertions check the safety ordering of the outputs: the clock only with power-good, the bulk switches only with the first group, the clamp whenever the bulk switches are off, and no power-good under clamp. They also check that the clock restart lags power-good by four cycles and that the switches drop only after the clamp has been up for a cycle. Only the bench scenarios can show the stage lengths for each programmed wait, the control word layout and readback, that a request is held through a running sequence, that the bit-0 write is ignored in hardware-trigger mode, and that override skips the waits.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int WAIT_W       = 4;
  localparam int REG_W        = 32;
  localparam int BIT_STATUS   = 31;
  localparam int BIT_COLLAPSE = 0;
  localparam int BIT_HWTRIG   = 1;
  localparam int BIT_OVR      = 2;
  localparam int LSB_CLKOFF   = 12;
  localparam int LSB_FEW      = 16;
  localparam int LSB_REST     = 20;

  typedef enum logic [2:0] {
    ST_OFF, ST_UP_FEW, ST_UP_REST, ST_UP_CLK, ST_ON, ST_DN_CLK, ST_DN_ISO
  } pds_state_e;

  typedef struct packed {
    logic few;
    logic rest;
    logic clamp;
    logic clk;
    logic good;
  } pds_out_t;
endpackage

// File: rtl/pds_ctrl_reg.sv
module pds_ctrl_reg
  import pds_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              good,
  output logic [REG_W-1:0]  rd_data,
  output logic              collapse,
  output logic              hw_trig,
  output logic              ovr,
  output logic [WAIT_W-1:0] w_few,
  output logic [WAIT_W-1:0] w_rest,
  output logic [WAIT_W-1:0] w_clkoff
);
  logic unused_wbits;
  assign unused_wbits = ^{wr_data[REG_W-1:LSB_REST+WAIT_W],
                          wr_data[LSB_CLKOFF-1:BIT_OVR+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      collapse <= 1'b1;
      hw_trig  <= 1'b0;
      ovr      <= 1'b0;
      w_few    <= '0;
      w_rest   <= '0;
      w_clkoff <= '0;
    end else if (wr_en) begin
      collapse <= wr_data[BIT_COLLAPSE];
      hw_trig  <= wr_data[BIT_HWTRIG];
      ovr      <= wr_data[BIT_OVR];
      w_few    <= wr_data[LSB_FEW +: WAIT_W];
      w_rest   <= wr_data[LSB_REST +: WAIT_W];
      w_clkoff <= wr_data[LSB_CLKOFF +: WAIT_W];
    end
  end

  always_comb begin
    rd_data                        = '0;
    rd_data[BIT_STATUS]            = good;
    rd_data[BIT_COLLAPSE]          = collapse;
    rd_data[BIT_HWTRIG]            = hw_trig;
    rd_data[BIT_OVR]               = ovr;
    rd_data[LSB_FEW +: WAIT_W]     = w_few;
    rd_data[LSB_REST +: WAIT_W]    = w_rest;
    rd_data[LSB_CLKOFF +: WAIT_W]  = w_clkoff;
  end
endmodule

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
  import pds_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int CLK_RESTART = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want_off,
  input  logic              ovr,
  input  logic              done,
  input  logic [WAIT_W-1:0] w_few,
  input  logic [WAIT_W-1:0] w_rest,
  input  logic [WAIT_W-1:0] w_clkoff,
  output pds_state_e        state,
  output logic              load,
  output logic [CNT_W-1:0]  load_val
);
  pds_state_e nxt;

  function automatic logic [CNT_W-1:0] pow2m1(input logic [WAIT_W-1:0] n);
    return (CNT_W'(1) << n) - CNT_W'(1);
  endfunction

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    if (ovr) begin
      nxt = want_off ? ST_OFF : ST_ON;
    end else begin
      unique case (state)
        ST_OFF: if (!want_off) begin
          nxt = ST_UP_FEW; load = 1'b1; load_val = pow2m1(w_few);
        end
        ST_UP_FEW: if (done) begin
          nxt = ST_UP_REST; load = 1'b1; load_val = pow2m1(w_rest);
        end
        ST_UP_REST: if (done) begin
          nxt = ST_UP_CLK; load = 1'b1; load_val = CNT_W'(CLK_RESTART - 1);
        end
        ST_UP_CLK: if (done) nxt = ST_ON;
        ST_ON: if (want_off) begin
          nxt = ST_DN_CLK; load = 1'b1; load_val = pow2m1(w_clkoff);
        end
        ST_DN_CLK: if (done) nxt = ST_DN_ISO;
        ST_DN_ISO: nxt = ST_OFF;
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end
endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pds_pkg::*;
#(
  parameter int CLK_RESTART = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              hw_collapse_req,
  output logic              sw_few_en,
  output logic              sw_rest_en,
  output logic              iso_clamp,
  output logic              clk_en,
  output logic              pwr_good
);
  localparam int CNT_W = 1 << WAIT_W;

  logic              collapse, hw_trig, ovr, want_off, done, load;
  logic [WAIT_W-1:0] w_few, w_rest, w_clkoff;
  logic [CNT_W-1:0]  load_val;
  pds_state_e        state;
  pds_out_t          o;

  pds_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .good(o.good), .rd_data(rd_data), .collapse(collapse),
    .hw_trig(hw_trig), .ovr(ovr), .w_few(w_few), .w_rest(w_rest),
    .w_clkoff(w_clkoff)
  );

  assign want_off = hw_trig ? hw_collapse_req : collapse;

  pds_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .done(done)
  );

  pds_fsm #(.CNT_W(CNT_W), .CLK_RESTART(CLK_RESTART)) u_fsm (
    .clk(clk), .rst_n(rst_n), .want_off(want_off), .ovr(ovr), .done(done),
    .w_few(w_few), .w_rest(w_rest), .w_clkoff(w_clkoff),
    .state(state), .load(load), .load_val(load_val)
  );

  always_comb begin
    unique case (state)
      ST_UP_FEW:  o = '{few:1'b1, rest:1'b0, clamp:1'b1, clk:1'b0, good:1'b0};
      ST_UP_REST: o = '{few:1'b1, rest:1'b1, clamp:1'b1, clk:1'b0, good:1'b0};
      ST_UP_CLK:  o = '{few:1'b1, rest:1'b1, clamp:1'b0, clk:1'b0, good:1'b1};
      ST_ON:      o = '{few:1'b1, rest:1'b1, clamp:1'b0, clk:1'b1, good:1'b1};
      ST_DN_CLK:  o = '{few:1'b1, rest:1'b1, clamp:1'b0, clk:1'b0, good:1'b0};
      ST_DN_ISO:  o = '{few:1'b1, rest:1'b1, clamp:1'b1, clk:1'b0, good:1'b0};
      default:    o = '{few:1'b0, rest:1'b0, clamp:1'b1, clk:1'b0, good:1'b0};
    endcase
  end

  assign sw_few_en  = o.few;
  assign sw_rest_en = o.rest;
  assign iso_clamp  = o.clamp;
  assign clk_en     = o.clk;
  assign pwr_good   = o.good;
endmodule

// File: rtl/pds_checker.sv
module pds_checker (
  input logic clk,
  input logic rst_n,
  input logic sw_few_en,
  input logic sw_rest_en,
  input logic iso_clamp,
  input logic clk_en,
  input logic pwr_good,
  input logic ovr_mode
);
  a_r10_clk_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> pwr_good);

  a_r10_rest_needs_few: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rest_en |-> sw_few_en);

  a_r10_clamp_when_rest_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rest_en |-> iso_clamp);

  a_r4_good_unclamped: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> !iso_clamp);

  a_r5_clk_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_en) && !ovr_mode) |-> $past(pwr_good, 4));

  a_r6_clamp_before_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sw_few_en) && !ovr_mode) |-> $past(iso_clamp));
endmodule

bind pwr_dom_seq pds_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sw_few_en(sw_few_en), .sw_rest_en(sw_rest_en),
  .iso_clamp(iso_clamp), .clk_en(clk_en), .pwr_good(pwr_good),
  .ovr_mode(rd_data[2])
);

// File: tb/sim_pwr_dom_seq.sv
module sim_pwr_dom_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        hw_collapse_req = 1'b1;
  logic        sw_few_en, sw_rest_en, iso_clamp, clk_en, pwr_good;
  int          n_run = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  pwr_dom_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .hw_collapse_req(hw_collapse_req),
    .sw_few_en(sw_few_en), .sw_rest_en(sw_rest_en), .iso_clamp(iso_clamp),
    .clk_en(clk_en), .pwr_good(pwr_good)
  );

  // stimulus table: [11:8] first-group wait, [7:4] bulk wait, [3:0] clock-off wait
  localparam logic [11:0] VEC [0:5] = '{12'h000, 12'h111, 12'h230,
                                        12'h024, 12'h512, 12'h355};
  localparam int LIMIT = 70000;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int f, input int r, input int c,
                                     input bit o, input bit h, input bit col);
    logic [31:0] w = '0;
    w[23:20] = r[3:0];
    w[19:16] = f[3:0];
    w[15:12] = c[3:0];
    w[2] = o; w[1] = h; w[0] = col;
    return w;
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic meas_up(output int t_few, output int t_rest,
                         output int t_good, output int t_clk);
    t_few = -1; t_rest = -1; t_good = -1; t_clk = -1;
    for (int n = 1; n <= LIMIT && t_clk < 0; n++) begin
      @(negedge clk);
      if (sw_few_en  && t_few  < 0) t_few  = n;
      if (sw_rest_en && t_rest < 0) t_rest = n;
      if (pwr_good   && t_good < 0) t_good = n;
      if (clk_en     && t_clk  < 0) t_clk  = n;
    end
  endtask

  task automatic meas_dn(output int t_good, output int t_clk,
                         output int t_clamp, output int t_off);
    t_good = -1; t_clk = -1; t_clamp = -1; t_off = -1;
    for (int n = 1; n <= LIMIT && t_off < 0; n++) begin
      @(negedge clk);
      if (!pwr_good && t_good  < 0) t_good  = n;
      if (!clk_en   && t_clk   < 0) t_clk   = n;
      if (iso_clamp && t_clamp < 0) t_clamp = n;
      if (!sw_few_en && !sw_rest_en && t_off < 0) t_off = n;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int a, b, c, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!sw_few_en && !sw_rest_en && iso_clamp && !clk_en && !pwr_good,
          "R1", "outputs {few,rest,clamp,clk,good}",
          {sw_few_en, sw_rest_en, iso_clamp, clk_en, pwr_good}, 5'b00100);
    check(rd_data == 32'h1, "R1", "reset word", rd_data, 32'h1);

    // R2 layout and readback, writes to bit 31 and reserved bits ignored
    wr(32'hFFFF_FFFF);
    check(rd_data == 32'h00FF_F007, "R2", "readback", rd_data, 32'h00FF_F007);
    wr(32'h0000_0001);
    check(rd_data == 32'h1, "R2", "readback cleared", rd_data, 32'h1);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      int f, r, cw, e_rest, e_good;
      f = int'(VEC[i][11:8]); r = int'(VEC[i][7:4]); cw = int'(VEC[i][3:0]);
      wr(mk(f, r, cw, 0, 0, 0));
      meas_up(a, b, c, d);
      e_rest = 1 + (1 << f);
      e_good = e_rest + (1 << r);
      check(a == 1, "R3", "first group rise", a, 1);
      check(b == e_rest, "R3", "bulk group rise", b, e_rest);
      check(c == e_good, "R4", "power-good rise", c, e_good);
      check(!iso_clamp, "R4", "clamp released", iso_clamp, 0);
      check(d == e_good + 4, "R5", "clock enable rise", d, e_good + 4);
      check(rd_data[31], "R2", "status bit when on", rd_data[31], 1);
      wr(mk(f, r, cw, 0, 0, 1));
      meas_dn(a, b, c, d);
      check(a == 1, "R6", "power-good fall", a, 1);
      check(b == 1, "R6", "clock enable fall", b, 1);
      check(c == 1 + (1 << cw), "R6", "clamp rise", c, 1 + (1 << cw));
      check(d == 2 + (1 << cw), "R6", "switches off", d, 2 + (1 << cw));
      check(!rd_data[31], "R2", "status bit when off", rd_data[31], 0);
    end

    // R7 request held during a running sequence
    begin
      bit saw_good, saw_clk;
      saw_good = 0; saw_clk = 0;
      wr(mk(3, 2, 1, 0, 0, 0));
      wr(mk(3, 2, 1, 0, 0, 1));
      for (int n = 0; n < 60; n++) begin
        @(negedge clk);
        if (pwr_good) saw_good = 1;
        if (clk_en)   saw_clk = 1;
      end
      check(saw_good, "R7", "power-good reached", saw_good, 1);
      check(saw_clk, "R7", "clock enable reached", saw_clk, 1);
      check(iso_clamp && !sw_few_en && !sw_rest_en, "R7", "ends off",
            {iso_clamp, sw_few_en, sw_rest_en}, 3'b100);
    end

    // R8 hardware-trigger mode
    hw_collapse_req = 1'b1;
    wr(mk(1, 1, 1, 0, 1, 0));
    repeat (20) @(negedge clk);
    check(!sw_few_en && !pwr_good, "R8", "bit0 ignored while off",
          {sw_few_en, pwr_good}, 0);
    hw_collapse_req = 1'b0;
    meas_up(a, b, c, d);
    check(a == 1 && b == 3 && c == 5 && d == 9, "R8", "up timing good-cycle",
          c, 5);
    wr(mk(1, 1, 1, 0, 1, 1));
    repeat (20) @(negedge clk);
    check(pwr_good && clk_en, "R8", "bit0 ignored while on",
          {pwr_good, clk_en}, 2'b11);
    @(negedge clk); hw_collapse_req = 1'b1;
    meas_dn(a, b, c, d);
    check(a == 1 && c == 3 && d == 4, "R8", "down timing off-cycle", d, 4);

    // R9 software override, long waits bypassed
    wr(mk(15, 15, 15, 1, 0, 0));
    @(negedge clk);
    check(sw_few_en && sw_rest_en && !iso_clamp && clk_en && pwr_good, "R9",
          "full-on pattern", {sw_few_en, sw_rest_en, iso_clamp, clk_en, pwr_good},
          5'b11011);
    wr(mk(15, 15, 15, 1, 0, 1));
    @(negedge clk);
    check(!sw_few_en && !sw_rest_en && iso_clamp && !clk_en && !pwr_good, "R9",
          "full-off pattern", {sw_few_en, sw_rest_en, iso_clamp, clk_en, pwr_good},
          5'b00100);
    wr(mk(0, 0, 0, 0, 0, 1));
    repeat (5) @(negedge clk);
    check(!sw_few_en && iso_clamp, "R9", "stays off after override cleared",
          {sw_few_en, iso_clamp}, 2'b01);
    // R10 spot check in stable off state
    check(iso_clamp || sw_rest_en, "R10", "clamp with bulk off", iso_clamp, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule